// File: doc/BRIEF.md
# Analogue Input and Status Port Controller

This block sits on the slow peripheral page of an 8-bit processor bus. It turns a register write into a conversion request for an external four-channel analogue-to-digital converter. It captures the sample that the converter returns. It also presents a status byte that combines a conversion-end flag with a printer busy line and two fire-button inputs. Software writes a channel code to the command/result register at offset 0x70 of the page, waits for the flag to drop, and then reads the sample back from the same offset. The status byte is at offset 0x72.

A three-state machine drives the converter handshake:

- `ST_IDLE` has no conversion in flight.
- `ST_LAUNCH` lasts one cycle and holds the start pulse.
- `ST_WAIT` waits for the converter's done signal.

The transitions are:

- **accept**: any state to `ST_LAUNCH`, on a valid command write. A write during `LAUNCH` or `WAIT` restarts the conversion.
- **issue**: `ST_LAUNCH` to `ST_WAIT`, unconditionally.
- **finish**: `ST_WAIT` to `ST_IDLE`, on done.

Top module: `adc_port_ctl`

## Requirements
- R1: After reset the state is `ST_IDLE`, `adc_start` is low, `adc_chan` is 0, the result register is zero and status bit 6 reads 1.
- R2: A strobed write (`bus_stb`=1, `bus_page_sel`=1, `bus_rnw`=0) to offset 0x70 whose data is 4, 5, 6 or 7 raises `adc_start` in the following cycle for exactly one cycle. From that cycle `adc_chan` equals data minus 4, i.e. data bits [1:0].
- R3: A command write whose data is outside 4..7 is ignored. No start pulse follows, and `adc_chan`, status bit 6 and the result are unchanged.
- R4: Status bit 6 reads 1 from the cycle after an accepted command write. It reads 0 from the cycle after done is seen in `ST_WAIT`, and it stays 0 until the next accepted write.
- R5: When `adc_done` is high in `ST_WAIT`, `adc_data` is captured as the result. A read of offset 0x70 returns that result. A done pulse in `ST_IDLE` or `ST_LAUNCH` is ignored.
- R6: An accepted write during `ST_LAUNCH` or `ST_WAIT` restarts the conversion. A fresh one-cycle start follows, carrying the new channel.
- R7: Status bit 7 is printer busy, bit 5 is fire button 2 and bit 4 is fire button 1. Each passes through two synchronising flops, so a change shows two cycles later. Bits 3..0 read 0.
- R8: `bus_rdata` is 0 unless `bus_page_sel`=1 and `bus_rnw`=1 with offset 0x70 or 0x72. Writes to other offsets, and writes with the page unselected, have no effect.
- R9: If an accepted write and done arrive in the same cycle in `ST_WAIT`, the write wins. The result is unchanged, bit 6 stays 1 and a new start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Low byte of the bus address |
| bus_page_sel | input | 1 | Peripheral page is addressed |
| bus_wdata | input | 8 | Write data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | One-cycle access strobe |
| prn_busy_a | input | 1 | Printer busy, asynchronous |
| fire1_a | input | 1 | Fire button 1, asynchronous |
| fire2_a | input | 1 | Fire button 2, asynchronous |
| adc_done | input | 1 | Converter reports a sample ready |
| adc_data | input | 8 | Converter sample |
| bus_rdata | output | 8 | Read data |
| adc_start | output | 1 | One-cycle conversion start |
| adc_chan | output | 2 | Channel for the conversion |

## Verification
The hardest cases to reach from the ports are the ones where a command write lands on a state-machine edge. One is a second write during the single `ST_LAUNCH` cycle. The other is a write in exactly the cycle that done is high in `ST_WAIT`. The stimulus reaches both by issuing strobed writes on back-to-back cycles, and by raising `adc_done` together with the strobe. A behavioural model runs alongside and decides every cycle whether the start pulse, channel, flag and result must change.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } conv_state_e;
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/adc_port_fsm.sv
module adc_port_fsm
    import adc_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_start,
    output logic [CHAN_W-1:0] adc_chan,
    output logic              eoc_n,
    output logic [DATA_W-1:0] result
);
    conv_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (cmd_wr) begin
            st_nx = ST_LAUNCH;
        end else begin
            unique case (st)
                ST_IDLE:   st_nx = ST_IDLE;
                ST_LAUNCH: st_nx = ST_WAIT;
                ST_WAIT:   if (adc_done) st_nx = ST_IDLE;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_chan <= '0;
            eoc_n    <= 1'b1;
            result   <= '0;
        end else if (cmd_wr) begin
            adc_chan <= cmd_chan;
            eoc_n    <= 1'b1;
        end else if (st == ST_WAIT && adc_done) begin
            result   <= adc_data;
            eoc_n    <= 1'b0;
        end
    end

    assign adc_start = (st == ST_LAUNCH);
endmodule

// File: rtl/adc_port_rdmux.sv
module adc_port_rdmux #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  CMD_OFS  = 8'h70,
    parameter logic [7:0]  STAT_OFS = 8'h72
) (
    input  logic              page_sel,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (page_sel && rnw) begin
            if (addr == ADDR_W'(CMD_OFS))       rdata = result;
            else if (addr == ADDR_W'(STAT_OFS)) rdata = status;
        end
    end
endmodule

// File: rtl/adc_port_ctl.sv
module adc_port_ctl #(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         CHAN_W    = 2,
    parameter int         SYNC_STG  = 2,
    parameter int         CODE_BASE = 4,
    parameter logic [7:0] CMD_OFS   = 8'h70,
    parameter logic [7:0] STAT_OFS  = 8'h72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_page_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rnw,
    input  logic              bus_stb,
    input  logic              prn_busy_a,
    input  logic              fire1_a,
    input  logic              fire2_a,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              adc_start,
    output logic [CHAN_W-1:0] adc_chan
);
    localparam int                     HI_W    = DATA_W - CHAN_W;
    localparam logic [HI_W-1:0]        CODE_HI = HI_W'(CODE_BASE >> CHAN_W);
    localparam int                     N_SYNC  = 3;

    logic              code_ok;
    logic              cmd_wr;
    logic              eoc_n;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] status;
    logic [N_SYNC-1:0] sync_q;

    assign code_ok = (bus_wdata[DATA_W-1:CHAN_W] == CODE_HI);
    assign cmd_wr  = bus_stb && bus_page_sel && !bus_rnw &&
                     (bus_addr == ADDR_W'(CMD_OFS)) && code_ok;

    adc_port_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({prn_busy_a, fire2_a, fire1_a}),
        .q_sync  (sync_q)
    );

    adc_port_fsm #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_chan  (bus_wdata[CHAN_W-1:0]),
        .adc_done  (adc_done),
        .adc_data  (adc_data),
        .adc_start (adc_start),
        .adc_chan  (adc_chan),
        .eoc_n     (eoc_n),
        .result    (result)
    );

    always_comb begin
        status           = '0;
        status[DATA_W-1] = sync_q[2];
        status[DATA_W-2] = eoc_n;
        status[DATA_W-3] = sync_q[1];
        status[DATA_W-4] = sync_q[0];
    end

    adc_port_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS)
    ) u_rd (
        .page_sel (bus_page_sel),
        .rnw      (bus_rnw),
        .addr     (bus_addr),
        .result   (result),
        .status   (status),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/adc_port_chk.sv
module adc_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_page_sel,
    input logic [7:0] bus_wdata,
    input logic       bus_rnw,
    input logic       bus_stb,
    input logic       adc_done,
    input logic [7:0] bus_rdata,
    input logic       adc_start,
    input logic [1:0] adc_chan,
    input logic       eoc_n
);
    logic wr70, good;
    assign wr70 = bus_stb && bus_page_sel && !bus_rnw && bus_addr == 8'h70;
    assign good = wr70 && (bus_wdata >= 8'd4) && (bus_wdata <= 8'd7);

    // R2
    launch_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> (adc_start && adc_chan == $past(bus_wdata[1:0])));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && !good) |=> !adc_start);

    // R3
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr70 && !good && !adc_start) |=> (!adc_start && $stable(adc_chan)));

    // R4
    flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> eoc_n);

    // R4
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(adc_done));

    // R7
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_page_sel && bus_rnw && bus_addr == 8'h72) |-> bus_rdata[3:0] == 4'h0);

    // R8
    unselected_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_page_sel |-> bus_rdata == 8'h00);
endmodule

bind adc_port_ctl adc_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_page_sel (bus_page_sel),
    .bus_wdata    (bus_wdata),
    .bus_rnw      (bus_rnw),
    .bus_stb      (bus_stb),
    .adc_done     (adc_done),
    .bus_rdata    (bus_rdata),
    .adc_start    (adc_start),
    .adc_chan     (adc_chan),
    .eoc_n        (eoc_n)
);

// File: tb/adc_port_ctl_tb.sv
`timescale 1ns/1ps
module adc_port_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h72;
    logic       bus_page_sel = 1'b1;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rnw = 1'b1;
    logic       bus_stb = 1'b0;
    logic       prn_busy_a = 1'b0;
    logic       fire1_a = 1'b0;
    logic       fire2_a = 1'b0;
    logic       adc_done = 1'b0;
    logic [7:0] adc_data = 8'h00;
    logic [7:0] bus_rdata;
    logic       adc_start;
    logic [1:0] adc_chan;

    always #2 clk = ~clk;

    adc_port_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_page_sel(bus_page_sel),
        .bus_wdata(bus_wdata), .bus_rnw(bus_rnw), .bus_stb(bus_stb),
        .prn_busy_a(prn_busy_a), .fire1_a(fire1_a), .fire2_a(fire2_a),
        .adc_done(adc_done), .adc_data(adc_data), .bus_rdata(bus_rdata),
        .adc_start(adc_start), .adc_chan(adc_chan)
    );

    // behavioural reference: phase 0 idle, 1 launching, 2 waiting
    int         m_phase;
    int         m_chan;
    int         m_flag;
    int         m_result;
    int         m_hist[3][$];
    int         n_tests = 0;
    int         n_fail  = 0;
    string      cur_req = "R1";

    function automatic int late(int idx);
        if (m_hist[idx].size() < 2) return 0;
        return m_hist[idx][0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_chan = 0; m_flag = 1; m_result = 0;
            for (int i = 0; i < 3; i++) m_hist[i] = {0, 0};
        end else begin
            bit accept;
            accept = bus_stb && bus_page_sel && !bus_rnw && bus_addr == 8'h70 &&
                     bus_wdata >= 8'd4 && bus_wdata <= 8'd7;
            if (accept) begin
                m_phase = 1; m_chan = int'(bus_wdata) - 4; m_flag = 1;
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (m_phase == 2 && adc_done) begin
                m_result = int'(adc_data); m_flag = 0; m_phase = 0;
            end
            m_hist[0].push_back(int'(fire1_a));
            m_hist[1].push_back(int'(fire2_a));
            m_hist[2].push_back(int'(prn_busy_a));
            for (int i = 0; i < 3; i++) void'(m_hist[i].pop_front());
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (!(bus_page_sel && bus_rnw)) return 8'h00;
        if (bus_addr == 8'h70) return 8'(m_result);
        if (bus_addr == 8'h72)
            return {1'(late(2)), 1'(m_flag), 1'(late(1)), 1'(late(0)), 4'h0};
        return 8'h00;
    endfunction

    task automatic check(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check("adc_start", int'(adc_start), int'(m_phase == 1));
        check("adc_chan", int'(adc_chan), m_chan);
        check("bus_rdata", int'(bus_rdata), int'(exp_rdata()));
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, logic sel, logic done);
        bus_addr = a; bus_wdata = d; bus_page_sel = sel; bus_rnw = 1'b0;
        bus_stb = 1'b1; adc_done = done;
        tick();
        bus_stb = 1'b0; bus_rnw = 1'b1; bus_page_sel = 1'b1; adc_done = 1'b0;
    endtask

    task automatic done_pulse(logic [7:0] d);
        adc_done = 1'b1; adc_data = d;
        tick();
        adc_done = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, int n);
        bus_addr = a; bus_rnw = 1'b1;
        for (int i = 0; i < n; i++) tick();
    endtask

    bit finished = 1'b0;
    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h72, 2);
        rd(8'h70, 1);

        cur_req = "R3";
        wr(8'h70, 8'h03, 1'b1, 1'b0);
        wr(8'h70, 8'h08, 1'b1, 1'b0);
        wr(8'h70, 8'hFF, 1'b1, 1'b0);
        rd(8'h72, 2);

        cur_req = "R2";
        wr(8'h70, 8'h05, 1'b1, 1'b0);
        rd(8'h72, 3);

        cur_req = "R5";
        done_pulse(8'hA5);
        rd(8'h70, 2);
        done_pulse(8'h3C);
        rd(8'h70, 1);

        cur_req = "R4";
        rd(8'h72, 3);

        cur_req = "R3";
        wr(8'h70, 8'h01, 1'b1, 1'b0);
        rd(8'h72, 2);

        cur_req = "R6";
        wr(8'h70, 8'h06, 1'b1, 1'b0);
        wr(8'h70, 8'h07, 1'b1, 1'b0);
        rd(8'h72, 2);
        wr(8'h70, 8'h04, 1'b1, 1'b0);
        rd(8'h72, 1);

        cur_req = "R9";
        adc_data = 8'h77;
        wr(8'h70, 8'h06, 1'b1, 1'b1);
        rd(8'h70, 2);
        done_pulse(8'h5A);
        rd(8'h70, 1);
        rd(8'h72, 1);

        cur_req = "R5";
        wr(8'h70, 8'h05, 1'b1, 1'b0);
        done_pulse(8'h11);
        rd(8'h72, 1);
        done_pulse(8'h22);
        rd(8'h70, 1);

        cur_req = "R7";
        bus_addr = 8'h72;
        fire1_a = 1'b1; tick(); tick(); tick();
        fire2_a = 1'b1; tick(); tick();
        prn_busy_a = 1'b1; fire1_a = 1'b0; tick(); tick(); tick();

        cur_req = "R8";
        wr(8'h72, 8'h05, 1'b1, 1'b0);
        wr(8'h70, 8'h05, 1'b0, 1'b0);
        rd(8'h72, 2);
        rd(8'h71, 1);
        bus_page_sel = 1'b0;
        rd(8'h70, 1);
        bus_page_sel = 1'b1;
        rd(8'h70, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule